// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block holds the interrupt enable and interrupt status registers of a graphics adapter. Five event sources feed it: vertical blank start, vertical blank end (the start of a new picture frame), sprite display complete, command completion, and a register write that was rejected because a command was still running. Every event arrives as a single-cycle pulse and latches a sticky status bit. The bit latches whether or not its enable bit is set.

Software clears status bits by writing ones to their positions. A single level-sensitive interrupt request goes high while any status bit is set together with its enable bit. The block generates the reject event itself. It raises the event when a memory-mapped register write strobe arrives while the command engine reports busy.

Top module: `irq_status_ctl`

## Requirements
- R1: After reset, the enable register, the status register and `irq` are all 0.
- R2: An input pulse sets its status bit at the next clock edge, whatever the enable bit holds. The status bit positions are: bit 0 for `ev_vblank_start`, bit 1 for `ev_vblank_end`, bit 2 for `ev_sprite_done` and bit 7 for `ev_cmd_done`.
- R3: Status bit 6 (access reject) is set at the next edge when `mmio_wr` is high in a cycle where `cmd_busy` is high. If `cmd_busy` is low, `mmio_wr` has no effect on status.
- R4: A write with `wr_en`=1 and `wr_sel`=1 clears each status bit whose `wr_data` bit is 1. Status bits whose `wr_data` bit is 0 keep their value.
- R5: When a status bit's event and a clear of that same bit fall in the same cycle, the bit ends up set.
- R6: A write with `wr_en`=1 and `wr_sel`=0 loads the enable register from `wr_data`. In both registers, bits 3 to 5 always read 0 and ignore writes.
- R7: `irq` is 1 exactly while the bitwise AND of status and enable is non-zero. It follows register changes without any extra cycle of delay.
- R8: A set status bit stays set until it is cleared as in R4. Writes to the enable register do not change the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_vblank_start | input | 1 | Pulse: vertical blank begins |
| ev_vblank_end | input | 1 | Pulse: vertical blank ends, new frame |
| ev_sprite_done | input | 1 | Pulse: sprite has been fully displayed |
| ev_cmd_done | input | 1 | Pulse: graphics command finished |
| cmd_busy | input | 1 | Command engine is running |
| mmio_wr | input | 1 | Memory-mapped register write strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects enable register, 1 selects status register |
| wr_data | input | 8 | Write data |
| en_rd | output | 8 | Enable register contents |
| stat_rd | output | 8 | Status register contents |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets several corner cases:
- An event and a clear of the same bit landing in the same cycle. A design where clear has priority would lose the event.
- Status bits latching while their enable bits are clear. A design that gated status by enable would miss these.
- Write strobes arriving while the command engine is idle. A wrong reject detector would flag them.
- Ones written to bits 3 to 5. A design that stored them would read them back.

Random traffic also writes zeros to status bits and mixes enable writes into the stimulus. A design that cleared status on a zero, or disturbed status on an enable write, would drop sticky bits.

// File: rtl/irq_status_ctl.sv
module irq_status_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_vblank_start,
  input  logic       ev_vblank_end,
  input  logic       ev_sprite_done,
  input  logic       ev_cmd_done,
  input  logic       cmd_busy,
  input  logic       mmio_wr,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] en_rd,
  output logic [7:0] stat_rd,
  output logic       irq
);
  localparam logic [7:0] LIVE = 8'hC7;

  logic [7:0] en_q, stat_q, set_v, clr_v;
  logic       reject;

  assign reject = mmio_wr & cmd_busy;
  assign set_v  = {ev_cmd_done, reject, 3'b000, ev_sprite_done, ev_vblank_end, ev_vblank_start};
  assign clr_v  = (wr_en && wr_sel) ? (wr_data & LIVE) : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 8'h00;
      stat_q <= 8'h00;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (wr_en && !wr_sel) en_q <= wr_data & LIVE;
    end
  end

  assign en_rd   = en_q;
  assign stat_rd = stat_q;
  assign irq     = |(stat_q & en_q);
endmodule

module irq_status_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_vblank_start,
  input logic       ev_cmd_done,
  input logic       cmd_busy,
  input logic       mmio_wr,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] en_rd,
  input logic [7:0] stat_rd,
  input logic       irq
);
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rd[5:3] == 3'b000) && (stat_rd[5:3] == 3'b000));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vblank_start |=> stat_rd[0]);

  p_cmd_done_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd_done && wr_en && wr_sel && wr_data[7]) |=> stat_rd[7]);

  p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_wr && cmd_busy) |=> stat_rd[6]);

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_rd & en_rd) != 8'h00));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel) |=> ((~stat_rd & $past(stat_rd)) == 8'h00));
endmodule

bind irq_status_ctl irq_status_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_vblank_start(ev_vblank_start),
  .ev_cmd_done(ev_cmd_done), .cmd_busy(cmd_busy), .mmio_wr(mmio_wr),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .en_rd(en_rd), .stat_rd(stat_rd), .irq(irq)
);

// File: tb/irq_status_ctl_tb.sv
module irq_status_ctl_tb;
  logic clk = 0, rst_n = 0;
  logic ev_vs = 0, ev_ve = 0, ev_sp = 0, ev_cd = 0, busy = 0, mmio = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] en_rd, stat_rd;
  logic irq;
  int total = 0, bad = 0;
  logic [7:0] m_en = 0, m_st = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_status_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_vblank_start(ev_vs), .ev_vblank_end(ev_ve),
    .ev_sprite_done(ev_sp), .ev_cmd_done(ev_cd), .cmd_busy(busy), .mmio_wr(mmio),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .en_rd(en_rd), .stat_rd(stat_rd), .irq(irq));

  function automatic logic [7:0] next_stat(logic [7:0] st);
    logic [7:0] s = st;
    if (wr_en && wr_sel) s = s & ~wr_data;
    s[0] |= ev_vs; s[1] |= ev_ve; s[2] |= ev_sp; s[7] |= ev_cd;
    s[6] |= mmio & busy;
    return s & 8'hC7;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    m_st = next_stat(m_st);
    if (wr_en && !wr_sel) m_en = wr_data & 8'hC7;
    @(negedge clk);
    chk({req, " stat"}, stat_rd, m_st);
    chk({req, " en"}, en_rd, m_en);
    chk("R7 irq", {7'd0, irq}, {7'd0, |(m_st & m_en)});
    {ev_vs, ev_ve, ev_sp, ev_cd, busy, mmio, wr_en, wr_sel} = '0;
    wr_data = 0;
  endtask

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk("R1 en", en_rd, 8'h00);
    chk("R1 stat", stat_rd, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1;
    // R2: events latch with enables clear
    ev_vs = 1; ev_sp = 1; step("R2");
    ev_ve = 1; ev_cd = 1; step("R2");
    chk("R2 all four", stat_rd, 8'h87);
    // R3: idle write strobe does nothing, busy one rejects
    mmio = 1; step("R3");
    busy = 1; mmio = 1; step("R3");
    chk("R3 reject", stat_rd, 8'hC7);
    // R6: reserved bits ignored
    wr_en = 1; wr_sel = 0; wr_data = 8'hFF; step("R6");
    chk("R6 en", en_rd, 8'hC7);
    // R8: enable write leaves status
    wr_en = 1; wr_sel = 0; wr_data = 8'h00; step("R8");
    chk("R8 stat kept", stat_rd, 8'hC7);
    // R4: write ones clears, zeros keep
    wr_en = 1; wr_sel = 1; wr_data = 8'h05; step("R4");
    chk("R4 partial", stat_rd, 8'hC2);
    // R5: set wins against clear
    wr_en = 1; wr_sel = 1; wr_data = 8'hFF; ev_cd = 1; step("R5");
    chk("R5 set wins", stat_rd, 8'h80);
    // R7: irq level follows enable
    wr_en = 1; wr_sel = 0; wr_data = 8'h80; step("R7");
    chk("R7 irq on", {7'd0, irq}, 8'h01);
    wr_en = 1; wr_sel = 1; wr_data = 8'h80; step("R7");
    chk("R7 irq off", {7'd0, irq}, 8'h00);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      ev_vs = ($urandom % 8) == 0; ev_ve = ($urandom % 8) == 0;
      ev_sp = ($urandom % 8) == 0; ev_cd = ($urandom % 8) == 0;
      busy = $urandom; mmio = ($urandom % 4) == 0;
      wr_en = ($urandom % 3) == 0; wr_sel = $urandom; wr_data = 8'($urandom);
      step("R2 R3 R4 R5 R8 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); total++; bad++; $display("FAIL watchdog"); end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule